// File: doc/BRIEF.md
# Field-Start Line Enable Sequencer

This block produces the line-rate enable strobes that pace the memory ports and the main output bus of a video field-rate converter. A rising edge on the field-start input marks cycle 0 of a field. From that edge the block counts clock cycles and lines, and opens one enable window per port. Each window sits behind a fixed pipeline latency and, for three of the ports, behind a programmable shift.

The output and write ports also lag the input by whole lines, because the data path has a three-line algorithmic delay. Main output begins while the fourth input line is being read. The write ports follow one line and twelve cycles after that.

Inside each line a window stays open for a configured number of active pixels. The pattern repeats with the configured line period and stops after the configured number of lines. The shift values are captured at field start. A fresh field-start edge restarts every port, even when the previous field has not finished.

Top module: `line_enable_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a field-start edge arrives, all four enables are low. A reset in mid-field forces them low, and they stay low until the next edge.
- R2: `rd_ce_en` first goes high exactly 62 + `shift_ce` cycles after the clock edge that samples `fld_start` rising. That edge counts as cycle 0.
- R3: `rd_a_en` first goes high exactly 93 + `shift_a` cycles after cycle 0.
- R4: `out_fg_en` first goes high exactly 147 + 3×`line_len` cycles after cycle 0. It takes no shift.
- R5: `wr_bd_en` first goes high exactly 159 + 4×`line_len` + `shift_bd` cycles after cycle 0. With a zero shift this is one line plus 12 cycles after `out_fg_en`.
- R6: Once a window has started, the enable is high for the first `act_len` cycles of every `line_len`-cycle period and low for the rest of it.
- R7: Each enable produces exactly `field_lines` active periods. After that it stays low until the next field-start edge.
- R8: Each shift value is an unsigned 8-bit cycle count sampled at cycle 0. Changing a shift input during a field has no effect on that field's enables.
- R9: A new rising edge of `fld_start` restarts the timing of all four ports from cycle 0, even if the previous field is unfinished.
- R10: Holding `fld_start` high, or leaving it high, starts nothing. Only a low-to-high transition starts a field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fld_start | input | 1 | Field-start read enable; its rising edge defines cycle 0 |
| line_len | input | LEN_W | Line period in clock cycles (at least 2) |
| act_len | input | LEN_W | Active cycles per line (no more than `line_len`) |
| field_lines | input | LINES_W | Lines per field (at least 1) |
| shift_ce | input | SHIFT_W | Extra delay for the C/E read enable |
| shift_a | input | SHIFT_W | Extra delay for the A read enable |
| shift_bd | input | SHIFT_W | Extra delay for the B/D write enable |
| rd_ce_en | output | 1 | C/E read enable |
| rd_a_en | output | 1 | A read enable |
| out_fg_en | output | 1 | F/G output bus enable |
| wr_bd_en | output | 1 | B/D write enable |

## Verification
The bench builds the block with its default parameters: 12-bit line length, 10-bit line count and 8-bit shifts. It then drives short lines of 40 cycles at runtime, with 6 lines per field. These values bring a whole field within reach in under a thousand cycles, including the four-line lag of the write port and a shift of 255. They also let the bench compare every port against a cycle-exact model on every cycle, which covers the exact rise cycles, the line wrap and the end of the field. With the active width set equal to the line length, a window never closes between lines.

// File: rtl/line_enable_seq_pkg.sv
// Shared types for the line enable sequencer.
// Assumes nothing beyond the parameters of the top module.
package line_enable_seq_pkg;
    // Phase of one port's enable window.
    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_WAIT = 2'd1,
        WIN_RUN  = 2'd2
    } win_state_e;

    // Number of enable ports driven by the sequencer.
    localparam int NUM_PORTS = 4;
endpackage

// File: rtl/line_enable_start_det.sv
// Field-start edge detector.
// Emits a one-cycle start pulse when fld_start is sampled high after having
// been low (or after reset). Assumes fld_start is synchronous to clk.
module line_enable_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic fld_start,
    output logic start
);
    logic prev_q;

    // Remember last sampled level of the field-start input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= fld_start;
    end

    // Pulse only on a low-to-high transition.
    always_comb start = fld_start & ~prev_q;

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/line_enable_window.sv
// One port's enable window generator.
// On start it captures the total delay, counts it down, then emits
// field_lines periods of line_len cycles with the first act_len cycles high.
// Assumes line_len >= 2, act_len <= line_len, field_lines >= 1, and that
// the line configuration is stable during a field.
module line_enable_window
    import line_enable_seq_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int LINES_W = 10,
    parameter int DLY_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DLY_W-1:0]   dly,
    input  logic [LEN_W-1:0]   line_len,
    input  logic [LEN_W-1:0]   act_len,
    input  logic [LINES_W-1:0] field_lines,
    output logic               en
);
    win_state_e         state_q;
    logic [DLY_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   pos_q;
    logic [LINES_W-1:0] line_q;
    logic               last_pos;
    logic               last_line;

    // End-of-line and end-of-field markers.
    always_comb begin
        last_pos  = (pos_q == line_len - LEN_W'(1));
        last_line = (line_q == field_lines - LINES_W'(1));
    end

    // Delay countdown, then pixel and line counting for the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
            line_q  <= '0;
        end else if (start) begin
            cnt_q   <= dly;
            pos_q   <= '0;
            line_q  <= '0;
            state_q <= (dly == '0) ? WIN_RUN : WIN_WAIT;
        end else begin
            unique case (state_q)
                WIN_WAIT: begin
                    if (cnt_q == DLY_W'(1)) state_q <= WIN_RUN;
                    else                    cnt_q   <= cnt_q - DLY_W'(1);
                end
                WIN_RUN: begin
                    if (last_pos) begin
                        pos_q <= '0;
                        if (last_line) state_q <= WIN_IDLE;
                        else           line_q  <= line_q + LINES_W'(1);
                    end else begin
                        pos_q <= pos_q + LEN_W'(1);
                    end
                end
                default: state_q <= WIN_IDLE;
            endcase
        end
    end

    // Window is open for the active part of each line.
    always_comb en = (state_q == WIN_RUN) && (pos_q < act_len);

    assert_restart_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dly != '0) |=> (state_q == WIN_WAIT && cnt_q == $past(dly)));

    assert_wait_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_WAIT && !start && cnt_q != DLY_W'(1))
            |=> (state_q == WIN_WAIT && cnt_q == $past(cnt_q) - DLY_W'(1)));

    assert_line_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_RUN && !start && last_pos && !last_line)
            |=> (pos_q == '0 && line_q == $past(line_q) + LINES_W'(1)));

    assert_field_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_RUN && !start && last_pos && last_line)
            |=> (state_q == WIN_IDLE && !en));

    assert_rise_at_line_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (pos_q == '0));
endmodule

// File: rtl/line_enable_seq.sv
// Field-start line enable sequencer (top).
// Detects the field-start edge, forms each port's total delay from a fixed
// latency, a whole-line lag and an optional shift, and runs one window
// generator per port. Shifts and line length are consumed at field start.
module line_enable_seq
    import line_enable_seq_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int LINES_W     = 10,
    parameter int SHIFT_W     = 8,
    parameter int BASE_CE     = 62,
    parameter int BASE_A      = 93,
    parameter int BASE_FG     = 147,
    parameter int BASE_BD     = 159,
    parameter int LAG_FG      = 3,
    parameter int LAG_BD      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fld_start,
    input  logic [LEN_W-1:0]   line_len,
    input  logic [LEN_W-1:0]   act_len,
    input  logic [LINES_W-1:0] field_lines,
    input  logic [SHIFT_W-1:0] shift_ce,
    input  logic [SHIFT_W-1:0] shift_a,
    input  logic [SHIFT_W-1:0] shift_bd,
    output logic               rd_ce_en,
    output logic               rd_a_en,
    output logic               out_fg_en,
    output logic               wr_bd_en
);
    localparam int DLY_W = LEN_W + 4;

    logic                  start;
    logic [DLY_W-1:0]      len_ext;
    logic [DLY_W-1:0]      dly   [NUM_PORTS];
    logic [NUM_PORTS-1:0]  en_vec;

    line_enable_start_det u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld_start (fld_start),
        .start     (start)
    );

    // Total delay per port: fixed latency + line lag + sampled shift.
    always_comb begin
        len_ext = DLY_W'(line_len);
        dly[0]  = DLY_W'(BASE_CE) + DLY_W'(shift_ce);
        dly[1]  = DLY_W'(BASE_A)  + DLY_W'(shift_a);
        dly[2]  = DLY_W'(BASE_FG) + DLY_W'(LAG_FG) * len_ext;
        dly[3]  = DLY_W'(BASE_BD) + DLY_W'(LAG_BD) * len_ext + DLY_W'(shift_bd);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        line_enable_window #(
            .LEN_W   (LEN_W),
            .LINES_W (LINES_W),
            .DLY_W   (DLY_W)
        ) u_win (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (start),
            .dly         (dly[p]),
            .line_len    (line_len),
            .act_len     (act_len),
            .field_lines (field_lines),
            .en          (en_vec[p])
        );
    end

    // Map window outputs to the named strobes.
    always_comb begin
        rd_ce_en  = en_vec[0];
        rd_a_en   = en_vec[1];
        out_fg_en = en_vec[2];
        wr_bd_en  = en_vec[3];
    end

    assert_order_fg_bd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && shift_bd == '0) |=> (dly[3] - dly[2] == DLY_W'(BASE_BD - BASE_FG) + len_ext
                                       || start));
endmodule

// File: tb/line_enable_seq_bench.sv
// Directed bench: one task per scenario, each comparing all four enables
// every cycle against a cycle model built from the requirements.
module line_enable_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fld_start = 1'b0;
    logic [11:0] line_len = 12'd40;
    logic [11:0] act_len = 12'd24;
    logic [9:0]  field_lines = 10'd6;
    logic [7:0]  shift_ce = 8'd0;
    logic [7:0]  shift_a = 8'd0;
    logic [7:0]  shift_bd = 8'd0;
    logic        rd_ce_en, rd_a_en, out_fg_en, wr_bd_en;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit m_live = 1'b0;
    bit m_prev = 1'b0;
    int m_t = 0;
    int m_dly [4];
    int m_len = 40;
    int m_act = 24;
    int m_lines = 6;

    line_enable_seq u_line_enable_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fld_start   (fld_start),
        .line_len    (line_len),
        .act_len     (act_len),
        .field_lines (field_lines),
        .shift_ce    (shift_ce),
        .shift_a     (shift_a),
        .shift_bd    (shift_bd),
        .rd_ce_en    (rd_ce_en),
        .rd_a_en     (rd_a_en),
        .out_fg_en   (out_fg_en),
        .wr_bd_en    (wr_bd_en)
    );

    always #5 clk = ~clk;

    // Model update at each edge, from the inputs the design samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_live = 1'b0;
            m_prev = 1'b0;
        end else begin
            if (fld_start && !m_prev) begin
                m_live = 1'b1;
                m_t = 0;
                m_len = int'(line_len);
                m_act = int'(act_len);
                m_lines = int'(field_lines);
                m_dly[0] = 62 + int'(shift_ce);
                m_dly[1] = 93 + int'(shift_a);
                m_dly[2] = 147 + 3 * m_len;
                m_dly[3] = 159 + 4 * m_len + int'(shift_bd);
            end else if (m_live) begin
                m_t = m_t + 1;
            end
            m_prev = fld_start;
        end
    end

    function automatic bit exp_en(int p);
        int rel;
        if (!m_live || m_t < m_dly[p]) return 1'b0;
        rel = m_t - m_dly[p];
        return (rel / m_len < m_lines) && (rel % m_len < m_act);
    endfunction

    // Advance one cycle and compare every port at the falling edge.
    task automatic step(string tag);
        logic [3:0] got;
        string req [4];
        req[0] = "R2"; req[1] = "R3"; req[2] = "R4"; req[3] = "R5";
        @(posedge clk);
        @(negedge clk);
        got = {wr_bd_en, out_fg_en, rd_a_en, rd_ce_en};
        for (int p = 0; p < 4; p++) begin
            vectors++;
            if (got[p] !== exp_en(p)) begin
                errors++;
                $display("FAIL %s %s R6 R7 port=%0d t=%0d actual=%0b expected=%0b",
                         tag, req[p], p, m_t, got[p], exp_en(p));
            end
        end
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // R1: reset state and idle before any field start.
    task automatic t_reset();
        rst_n = 1'b0;
        fld_start = 1'b1;
        steps(3, "R1 in reset");
        fld_start = 1'b0;
        rst_n = 1'b1;
        steps(20, "R1 idle");
    endtask

    // R10: input held high for the whole field; R2..R7 with zero shifts.
    task automatic t_held_high();
        shift_ce = 8'd0; shift_a = 8'd0; shift_bd = 8'd0;
        fld_start = 1'b1;
        steps(700, "R10 held high");
        fld_start = 1'b0;
        steps(20, "R7 tail");
    endtask

    // R2 R3 R5 with largest shifts and a full-width window (R6).
    task automatic t_max_shift();
        line_len = 12'd40; act_len = 12'd40; field_lines = 10'd6;
        shift_ce = 8'd255; shift_a = 8'd255; shift_bd = 8'd255;
        fld_start = 1'b1;
        step("R6 full width start");
        fld_start = 1'b0;
        steps(900, "R6 full width");
        act_len = 12'd24;
    endtask

    // R8: shifts changed mid-field do not move this field's windows.
    task automatic t_shift_change();
        shift_ce = 8'd5; shift_a = 8'd9; shift_bd = 8'd3;
        fld_start = 1'b1;
        step("R8 start");
        fld_start = 1'b0;
        steps(30, "R8 before change");
        shift_ce = 8'd200; shift_a = 8'd1; shift_bd = 8'd100;
        steps(700, "R8 after change");
    endtask

    // R9: restart before the previous field finishes.
    task automatic t_restart();
        shift_ce = 8'd2; shift_a = 8'd4; shift_bd = 8'd6;
        field_lines = 10'd3; line_len = 12'd30; act_len = 12'd7;
        fld_start = 1'b1;
        step("R9 first start");
        fld_start = 1'b0;
        steps(290, "R9 first field");
        shift_ce = 8'd11;
        fld_start = 1'b1;
        step("R9 restart");
        fld_start = 1'b0;
        steps(500, "R9 second field");
    endtask

    // R1: reset in mid-field clears all enables until the next edge.
    task automatic t_mid_reset();
        fld_start = 1'b1;
        step("R1 start");
        fld_start = 1'b0;
        steps(260, "R1 before reset");
        rst_n = 1'b0;
        steps(2, "R1 mid reset");
        rst_n = 1'b1;
        steps(400, "R1 after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_held_high();
        t_max_shift();
        t_shift_change();
        t_restart();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule